// File: doc/BRIEF.md
# Capture-Compare Timer Channel

This block is one timer channel built around a free-running up-counter. The counter advances once every (div+1) clocks of the system clock, where div is an 8-bit divide field. A reference value is compared with the counter. A match fires only when the counter already equals the reference and the prescaler is about to advance the counter again. As a result, one compare period lasts (reference+1) prescaled intervals. After a match the counter either wraps to zero or keeps counting, depending on a restart bit.

A capture input passes through a two-flop synchronizer and then an edge detector. A selected edge copies the counter value into a capture register. The match event and the capture event each set a flag in an 8-bit event register, and software clears a flag by writing one to it. Flags that are set and enabled drive one request line. A DMA-select bit chooses which line that is: the interrupt line or the DMA request line. In DMA mode an acknowledge pulse clears the flags that are requesting.

Software reaches the channel through a flat register port. The port has a write strobe, a 3-bit address, a write word and a read word. The read word is combinational on the address.

Top module: `tmr_capture_compare`

## Requirements
- R1: With the channel running, two successive reference matches are exactly (ref+1)*(div+1) clocks apart. This holds for the corner case div=0, ref=0, where there is a match on every clock.
- R2: The restart bit is bit 10 of the mode word at address 0. When it is set, the counter returns to 0 at a match. When it is clear, the counter runs on past the reference value.
- R3: The capture edge field is bits 9:8 of the mode word, encoded 00 off, 01 rising, 10 falling, 11 either edge. A selected edge sets the capture flag and loads the counter value into the capture register at address 4. An edge that is not selected does neither.
- R4: A change on the capture input sets the capture flag on the third rising clock edge after the change, and not earlier.
- R5: The event register is at address 2. Bit 1 is the reference-match flag and bit 0 is the capture flag. Bits 7:2 read as zero.
- R6: Writing 1 to an event bit clears that flag. Writing 0 leaves it unchanged.
- R7: When an event and a clearing write to its flag fall on the same clock, the flag ends up set.
- R8: Bit 0 of the extended-mode word at address 1 selects the DMA route. When it is 0, pending requests drive irq. When it is 1, they drive dma_req. irq and dma_req are never high together.
- R9: The reference-match flag sets whatever the value of the request-enable bit (bit 11 of the mode word). It raises a request only while that bit is 1.
- R10: In DMA mode, a dma_ack pulse clears every flag that is requesting. When the DMA route is not selected, dma_ack has no effect.
- R11: After reset every register reads zero, and irq and dma_req are low.
- R12: A write to address 5 loads the counter. The counter holds while the run bit (bit 12 of the mode word) is 0. While the run bit is 1 with div=0, the counter gains one per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| cap_in | input | 1 | Asynchronous capture input |
| dma_ack | input | 1 | DMA acknowledge |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A prescaler phase that has drifted shows up as a wrong spacing between match requests. A compare off by one shows the same way, and both appear within the first full period. A synchronizer depth that is one flop short or long moves the capture flag by a clock, so the check one edge before the expected set catches it. A flag update with the wrong priority loses a capture that lands on the same clock as a clear, and the next read of the event register shows it. A routing error places a request on the wrong line, and this is visible in the cycle after the event.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
    localparam logic [ADDR_W-1:0] A_XMODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_EVENT = 3'd2;
    localparam logic [ADDR_W-1:0] A_REF   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

    localparam int EV_CAP_BIT = 0;
    localparam int EV_REF_BIT = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] psc_d, psc_q;

    always_comb begin
        tick  = run && (psc_q >= div);
        psc_d = psc_q;
        if (!run || tick) psc_d = '0;
        else              psc_d = psc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

    assert_tick_rephase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (psc_q == '0));
endmodule

// File: rtl/tmr_edge_detect.sv
module tmr_edge_detect
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      evt
);
    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   prev_d, prev_q;
    logic                   lvl, rise, fall;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pin};
        lvl    = sync_q[SYNC_STAGES-1];
        prev_d = lvl;
        rise   = lvl && !prev_q;
        fall   = !lvl && prev_q;
        unique case (sel)
            EDGE_RISE: evt = rise;
            EDGE_FALL: evt = fall;
            EDGE_ANY:  evt = rise || fall;
            default:   evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assert_off_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_OFF) |-> !evt);
endmodule

// File: rtl/tmr_req_router.sv
module tmr_req_router (
    input  logic ev_ref,
    input  logic ev_cap,
    input  logic ref_en,
    input  logic dma_sel,
    input  logic dma_ack,
    output logic irq,
    output logic dma_req,
    output logic ack_ref,
    output logic ack_cap
);
    logic ref_req, cap_req, any_req;

    always_comb begin
        ref_req = ev_ref && ref_en;
        cap_req = ev_cap;
        any_req = ref_req || cap_req;
        irq     = any_req && !dma_sel;
        dma_req = any_req && dma_sel;
        ack_ref = dma_ack && dma_sel && ref_req;
        ack_cap = dma_ack && dma_sel && cap_req;
    end
endmodule

// File: rtl/tmr_capture_compare.sv
module tmr_capture_compare
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    input  logic             cap_in,
    input  logic             dma_ack,
    output logic             irq,
    output logic             dma_req
);
    localparam int EDGE_LSB    = DIV_W;
    localparam int RESTART_BIT = DIV_W + 2;
    localparam int REFEN_BIT   = DIV_W + 3;
    localparam int RUN_BIT     = DIV_W + 4;
    localparam int MODE_W      = DIV_W + 5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        edge_sel_e        cap_edge;
        logic             restart;
        logic             ref_en;
        logic             run;
        logic             dma_sel;
        logic [CNT_W-1:0] ref_val;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             ev_ref;
        logic             ev_cap;
    } state_t;

    state_t s_d, s_q;
    logic   tick, cap_evt, hit;
    logic   ack_ref, ack_cap;
    logic   wr_mode, wr_xmode, wr_ev, wr_ref, wr_cnt;

    tmr_prescaler #(.DIV_W(DIV_W)) i_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (s_q.run),
        .div  (s_q.div),
        .tick (tick)
    );

    tmr_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_in),
        .sel  (s_q.cap_edge),
        .evt  (cap_evt)
    );

    tmr_req_router i_route (
        .ev_ref (s_q.ev_ref),
        .ev_cap (s_q.ev_cap),
        .ref_en (s_q.ref_en),
        .dma_sel(s_q.dma_sel),
        .dma_ack(dma_ack),
        .irq    (irq),
        .dma_req(dma_req),
        .ack_ref(ack_ref),
        .ack_cap(ack_cap)
    );

    always_comb begin
        s_d      = s_q;
        wr_mode  = wr_en && (addr == A_MODE);
        wr_xmode = wr_en && (addr == A_XMODE);
        wr_ev    = wr_en && (addr == A_EVENT);
        wr_ref   = wr_en && (addr == A_REF);
        wr_cnt   = wr_en && (addr == A_COUNT);
        hit      = s_q.run && tick && (s_q.cnt == s_q.ref_val);

        if (wr_mode) begin
            s_d.div      = wdata[DIV_W-1:0];
            s_d.cap_edge = edge_sel_e'(wdata[EDGE_LSB+1:EDGE_LSB]);
            s_d.restart  = wdata[RESTART_BIT];
            s_d.ref_en   = wdata[REFEN_BIT];
            s_d.run      = wdata[RUN_BIT];
        end
        if (wr_xmode) s_d.dma_sel = wdata[0];
        if (wr_ref)   s_d.ref_val = wdata;

        if (wr_cnt)
            s_d.cnt = wdata;
        else if (s_q.run && tick)
            s_d.cnt = (hit && s_q.restart) ? '0 : s_q.cnt + 1'b1;

        if (cap_evt) s_d.cap = s_q.cnt;

        s_d.ev_ref = hit || (s_q.ev_ref && !(wr_ev && wdata[EV_REF_BIT]) && !ack_ref);
        s_d.ev_cap = cap_evt || (s_q.ev_cap && !(wr_ev && wdata[EV_CAP_BIT]) && !ack_cap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_MODE:  rdata[MODE_W-1:0] = {s_q.run, s_q.ref_en, s_q.restart,
                                          s_q.cap_edge, s_q.div};
            A_XMODE: rdata[0] = s_q.dma_sel;
            A_EVENT: rdata[1:0] = {s_q.ev_ref, s_q.ev_cap};
            A_REF:   rdata = s_q.ref_val;
            A_CAPT:  rdata = s_q.cap;
            A_COUNT: rdata = s_q.cnt;
            default: rdata = '0;
        endcase
    end

    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && s_q.restart && !wr_cnt) |=> (s_q.cnt == '0));
    assert_match_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> s_q.ev_ref);
    assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ev && wdata[EV_CAP_BIT] && !cap_evt) |=> !s_q.ev_cap);
    assert_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && dma_req));
    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_EVENT) |-> (rdata[CNT_W-1:2] == '0));
endmodule

// File: tb/test_tmr_capture_compare.sv
module test_tmr_capture_compare;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cap_in = 1'b0;
    logic        dma_ack = 1'b0;
    logic        irq, dma_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    tmr_capture_compare i_tmr_capture_compare (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cap_in(cap_in), .dma_ack(dma_ack), .irq(irq), .dma_req(dma_req)
    );

    // {edge mode[1:0], new cap_in level, expected capture flag}
    localparam logic [3:0] CAP_VEC [8] = '{4'b0010, 4'b0000, 4'b0111, 4'b0100,
                                           4'b1010, 4'b1001, 4'b1111, 4'b1101};

    function automatic logic [31:0] mode_w(input logic [7:0] div, input logic [1:0] edg,
                                           input logic rst_b, input logic ren, input logic run);
        return {19'd0, run, ren, rst_b, edg, div};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset state
        chk("R11 irq", {31'd0, irq}, 0);
        chk("R11 dma_req", {31'd0, dma_req}, 0);
        for (int a = 0; a < 6; a++) begin
            rd(a[2:0], v);
            chk("R11 reg", v, 0);
        end

        // R12 counter load, hold and run
        wr(3'd5, 32'd1000);
        repeat (5) @(posedge clk);
        rd(3'd5, v); chk("R12 load hold", v, 32'd1000);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b0, 1'b0, 1'b1));
        repeat (9) @(posedge clk);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        rd(3'd5, v); chk("R12 run count", v, 32'd1010);

        // R3 capture edge table walk (counter stopped)
        for (int i = 0; i < 8; i++) begin
            wr(3'd0, mode_w(8'd0, CAP_VEC[i][3:2], 1'b0, 1'b0, 1'b0));
            wr(3'd5, 32'd100 + i);
            wr(3'd2, 32'd3);
            @(negedge clk) cap_in = CAP_VEC[i][1];
            repeat (5) @(posedge clk);
            rd(3'd2, v); chk("R3 capture flag", {31'd0, v[0]}, {31'd0, CAP_VEC[i][0]});
            if (CAP_VEC[i][0]) begin
                rd(3'd4, v); chk("R3 capture value", v, 32'd100 + i);
            end
        end

        // R4 and R7: synchronizer latency, set wins over clear
        wr(3'd0, mode_w(8'd0, 2'b01, 1'b0, 1'b0, 1'b0));
        wr(3'd5, 32'd77);
        wr(3'd2, 32'd3);
        @(negedge clk) cap_in = 1'b1;
        @(posedge clk);
        @(negedge clk) chk("R4 not after edge 1", {31'd0, rdata[0] & (addr == 3'd2)}, 0);
        addr = 3'd2;
        @(posedge clk);
        @(negedge clk);
        #1 chk("R4 not after edge 2", {31'd0, rdata[0]}, 0);
        wr_en = 1'b1; wdata = 32'd1;
        @(posedge clk);
        @(negedge clk) wr_en = 1'b0;
        #1 chk("R7 set wins over clear", {31'd0, rdata[0]}, 1);
        rd(3'd4, v); chk("R4 captured value", v, 32'd77);

        // R5 reserved bits and R6 write-one-to-clear
        wr(3'd2, 32'hFFFF_FFFC);
        rd(3'd2, v); chk("R6 write zero keeps", v, 32'd1);
        chk("R5 reserved zero", {24'd0, v[7:2], 2'd0}, 0);
        chk("R8 irq on capture", {31'd0, irq}, 1);
        wr(3'd2, 32'd1);
        rd(3'd2, v); chk("R6 write one clears", v, 0);

        // R8 and R10: DMA route and acknowledge
        wr(3'd1, 32'd1);
        @(negedge clk) cap_in = 1'b0;
        wr(3'd0, mode_w(8'd0, 2'b11, 1'b0, 1'b0, 1'b0));
        @(negedge clk) cap_in = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R8 dma route req", {31'd0, dma_req}, 1);
        chk("R8 dma route no irq", {31'd0, irq}, 0);
        dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
        chk("R10 ack drops req", {31'd0, dma_req}, 0);
        rd(3'd2, v); chk("R10 ack clears flag", v, 0);
        wr(3'd1, 32'd0);
        @(negedge clk) cap_in = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk) dma_ack = 1'b1;
        @(negedge clk) dma_ack = 1'b0;
        chk("R10 ack ignored in irq mode", {31'd0, irq}, 1);
        rd(3'd2, v); chk("R10 flag kept", v, 32'd1);
        wr(3'd2, 32'd3);

        // R9 reference flag without request enable
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b1, 1'b0, 1'b0));
        wr(3'd5, 32'd0);
        wr(3'd3, 32'd2);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b1, 1'b0, 1'b1));
        repeat (10) @(posedge clk);
        @(negedge clk) chk("R9 no request when disabled", {31'd0, irq}, 0);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b1, 1'b0, 1'b0));
        rd(3'd2, v); chk("R9 flag still set", v, 32'd2);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b1, 1'b1, 1'b0));
        @(negedge clk) chk("R9 request when enabled", {31'd0, irq}, 1);
        wr(3'd2, 32'd2);

        // R2 restart set: counter never exceeds reference
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b1, 1'b0, 1'b1));
        for (int i = 0; i < 7; i++) begin
            repeat (i + 1) @(posedge clk);
            rd(3'd5, v); chk("R2 restart bounded", {31'd0, v <= 32'd2}, 1);
        end
        // R2 restart clear: counter runs past reference
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        wr(3'd5, 32'd0);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b0, 1'b0, 1'b1));
        repeat (20) @(posedge clk);
        wr(3'd0, mode_w(8'd0, 2'b00, 1'b0, 1'b0, 1'b0));
        rd(3'd5, v); chk("R2 free run past ref", {31'd0, v > 32'd2}, 1);
        rd(3'd2, v); chk("R2 match flagged", v, 32'd2);
        wr(3'd2, 32'd3);

        // R1 period measurement for two settings
        for (int t = 0; t < 2; t++) begin
            logic [7:0] dv;
            logic [31:0] rv;
            dv = (t == 0) ? 8'd2 : 8'd0;
            rv = (t == 0) ? 32'd4 : 32'd0;
            wr(3'd0, mode_w(dv, 2'b00, 1'b1, 1'b1, 1'b0));
            wr(3'd5, 32'd0);
            wr(3'd3, rv);
            wr(3'd2, 32'd3);
            wr(3'd0, mode_w(dv, 2'b00, 1'b1, 1'b1, 1'b1));
            k = 0;
            while (!irq && k < 1000) begin
                @(negedge clk);
                k++;
            end
            wr_en = 1'b1; addr = 3'd2; wdata = 32'd2;
            k = 0;
            do begin
                @(posedge clk);
                k++;
                @(negedge clk) wr_en = 1'b0;
            end while (!irq && k < 1000);
            chk("R1 match period", k, (rv + 1) * (dv + 1));
            wr(3'd0, mode_w(dv, 2'b00, 1'b1, 1'b1, 1'b0));
            wr(3'd2, 32'd3);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule